// File: doc/BRIEF.md
# Accumulator Instruction Decoder and 8-bit ALU

This block takes one 14-bit instruction word of an accumulator machine together with the working register value, the data byte read from the addressed file register and the present carry flag. It decodes the word and computes the byte to be written back, where it goes (working register or file register), the file address, and new carry, digit-carry and zero flags, each with its own update enable. Which flags an instruction may change varies from one instruction to the next.

All outputs are registered: an instruction presented in one cycle produces its result on the outputs after the next rising clock edge. The surrounding core owns the program counter, the data memory and the status register storage. It applies the result and the flag enables. When the destination is the status register itself, the block has already merged the flag updates into the byte it writes.

Top module: `acc_alu14`

## Requirements
- R1: While rst_n is low, wr_en_o, to_file_o and all three flag enables are 0.
- R2: For byte-oriented instructions (bits 13:12 = 00), bit 7 selects the destination (0 = working register, 1 = file register). file_addr_o equals bits 6:0. Outputs reflect the instruction one clock edge after it is presented.
- R3: Add (file form: bits 13:8 = 000111; literal form: 11111x, x ignored) writes file (or literal) plus W, modulo 256. C is the carry out of bit 7, DC the carry out of bit 3, and Z is set when the result is zero. All three enables are 1.
- R4: Subtract (file form: 000010; literal form: 11110x) writes operand minus W. C is 1 when operand >= W, DC is 1 when the operand's low nibble >= W's low nibble, and Z is set on a zero result. All three enables are 1.
- R5: AND (000101, 111001), inclusive OR (000100, 111000), exclusive OR (000110, 111010), move-file (001000), complement (001001), increment (001010) and decrement (000011) write their result with only the Z enable set.
- R6: Rotate left (001101) gives {f[6:0], C} with new C = f[7]. Rotate right (001100) gives {C, f[7:1]} with new C = f[0]. Only the C enable is set.
- R7: Swap nibbles (001110), increment-skip (001111), decrement-skip (001011), move-W-to-file (000000 with bit 7 = 1) and return-with-literal (1101xx, result to W) write their result with no flag enable.
- R8: Bit clear (bits 13:10 = 0100) and bit set (0101) write the file byte back to the file register with only the bit numbered by bits 9:7 changed, and no flag enable.
- R9: Clear-file (000001 with bit 7 = 1) and clear-W (000001 with bit 7 = 0, bits 6:0 ignored) write 0x00 and set Z with its enable.
- R10: When the destination is file address STATUS_ADDR (default 3), each enabled flag replaces its bit in the written byte (C at bit 0, DC at bit 1, Z at bit 2). Clearing that register writes 0x04.
- R11: Words with bits 13:12 = 10, bits 13:11 = 011, bits 13:8 = 111011, or bits 13:7 = 0000000 write nothing and set no flag enable.
- R12: Move-literal (1100xx) writes bits 7:0 to W with no flag enable, whatever the two x bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Instruction word |
| w_i | input | 8 | Working register value |
| file_i | input | 8 | Byte read from the addressed file register |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Byte to write |
| wr_en_o | output | 1 | A write is to be made |
| to_file_o | output | 1 | 1: write to file register, 0: write to W |
| file_addr_o | output | 7 | File register address |
| c_o | output | 1 | New carry value |
| dc_o | output | 1 | New digit-carry value |
| z_o | output | 1 | New zero value |
| c_we_o | output | 1 | Carry update enable |
| dc_we_o | output | 1 | Digit-carry update enable |
| z_we_o | output | 1 | Zero update enable |

## Verification
A decode fault shows up at the ports one edge after the faulty word. It appears as a flag enable raised or missing for that opcode, or as a write that a reserved word should not make, and no later state hides it. The only state is the output stage, so a wrong value never lingers past the next instruction. Full sweeps of both operands for add and subtract, and of every byte for the one-operand operations, expose any wrong carry, digit-carry or zero edge on the cycle it occurs. The status-merge cases show whether flag bits override the written byte.

// File: rtl/acc_alu14_pkg.sv
package acc_alu14_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NIB_W  = DATA_W / 2;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BSEL_W = 3;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned INSN_W = OPC_W + DATA_W;
    localparam int unsigned HI_W   = INSN_W - ADDR_W;   // opcode plus destination bit

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR,
        OP_PASSF, OP_PASSW, OP_PASSK, OP_COM, OP_INC, OP_DEC,
        OP_RL, OP_RR, OP_SWAP, OP_BCLR, OP_BSET, OP_CLR
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    src_lit;
        logic    wr;
        logic    to_file;
        logic    upd_c;
        logic    upd_dc;
        logic    upd_z;
    } ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        logic              to_file;
        logic [ADDR_W-1:0] addr;
        logic              c_we;
        logic              dc_we;
        logic              z_we;
        logic              c;
        logic              dc;
        logic              z;
    } stage_t;
endpackage

// File: rtl/acc_alu14_decode.sv
module acc_alu14_decode
    import acc_alu14_pkg::*;
(
    input  logic [HI_W-1:0] hi_i,
    output ctrl_t           ctrl_o
);
    localparam ctrl_t NOTHING = '{op: OP_NONE, default: 1'b0};

    function automatic ctrl_t mk(alu_op_e op, logic lit, logic tf, logic [2:0] fl);
        ctrl_t r;
        r.op      = op;
        r.src_lit = lit;
        r.wr      = 1'b1;
        r.to_file = tf;
        r.upd_c   = fl[2];
        r.upd_dc  = fl[1];
        r.upd_z   = fl[0];
        return r;
    endfunction

    logic       dbit;
    logic [1:0] grp;
    logic [3:0] sub;

    assign dbit = hi_i[0];
    assign grp  = hi_i[HI_W-1 -: 2];
    assign sub  = hi_i[4:1];

    always_comb begin
        ctrl_o = NOTHING;
        unique case (grp)
            2'b00: begin
                unique case (sub)
                    4'h0: ctrl_o = dbit ? mk(OP_PASSW, 1'b0, 1'b1, 3'b000) : NOTHING;
                    4'h1: ctrl_o = mk(OP_CLR,   1'b0, dbit, 3'b001);
                    4'h2: ctrl_o = mk(OP_SUB,   1'b0, dbit, 3'b111);
                    4'h3: ctrl_o = mk(OP_DEC,   1'b0, dbit, 3'b001);
                    4'h4: ctrl_o = mk(OP_IOR,   1'b0, dbit, 3'b001);
                    4'h5: ctrl_o = mk(OP_AND,   1'b0, dbit, 3'b001);
                    4'h6: ctrl_o = mk(OP_XOR,   1'b0, dbit, 3'b001);
                    4'h7: ctrl_o = mk(OP_ADD,   1'b0, dbit, 3'b111);
                    4'h8: ctrl_o = mk(OP_PASSF, 1'b0, dbit, 3'b001);
                    4'h9: ctrl_o = mk(OP_COM,   1'b0, dbit, 3'b001);
                    4'hA: ctrl_o = mk(OP_INC,   1'b0, dbit, 3'b001);
                    4'hB: ctrl_o = mk(OP_DEC,   1'b0, dbit, 3'b000);
                    4'hC: ctrl_o = mk(OP_RR,    1'b0, dbit, 3'b100);
                    4'hD: ctrl_o = mk(OP_RL,    1'b0, dbit, 3'b100);
                    4'hE: ctrl_o = mk(OP_SWAP,  1'b0, dbit, 3'b000);
                    default: ctrl_o = mk(OP_INC, 1'b0, dbit, 3'b000);
                endcase
            end
            2'b01: begin
                if (!sub[3])
                    ctrl_o = mk(sub[2] ? OP_BSET : OP_BCLR, 1'b0, 1'b1, 3'b000);
            end
            2'b10: ctrl_o = NOTHING;
            default: begin
                casez (sub)
                    4'b0???: ctrl_o = mk(OP_PASSK, 1'b1, 1'b0, 3'b000);
                    4'b1000: ctrl_o = mk(OP_IOR,   1'b1, 1'b0, 3'b001);
                    4'b1001: ctrl_o = mk(OP_AND,   1'b1, 1'b0, 3'b001);
                    4'b1010: ctrl_o = mk(OP_XOR,   1'b1, 1'b0, 3'b001);
                    4'b110?: ctrl_o = mk(OP_SUB,   1'b1, 1'b0, 3'b111);
                    4'b111?: ctrl_o = mk(OP_ADD,   1'b1, 1'b0, 3'b111);
                    default: ctrl_o = NOTHING;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/acc_alu14_alu.sv
module acc_alu14_alu
    import acc_alu14_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              carry_i,
    input  logic [BSEL_W-1:0] bsel_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              dc_o,
    output logic              z_o
);
    logic [DATA_W:0]   sum, diff;
    logic [NIB_W:0]    nsum, ndiff;
    logic [DATA_W-1:0] bmask;

    always_comb begin
        sum   = {1'b0, opnd_i} + {1'b0, w_i};
        nsum  = {1'b0, opnd_i[NIB_W-1:0]} + {1'b0, w_i[NIB_W-1:0]};
        diff  = {1'b0, opnd_i} + {1'b0, ~w_i} + (DATA_W+1)'(1);
        ndiff = {1'b0, opnd_i[NIB_W-1:0]} + {1'b0, ~w_i[NIB_W-1:0]} + (NIB_W+1)'(1);
        bmask = DATA_W'(1) << bsel_i;
        res_o = '0;
        c_o   = 1'b0;
        dc_o  = 1'b0;
        unique case (op_i)
            OP_ADD:   begin res_o = sum[DATA_W-1:0];  c_o = sum[DATA_W];  dc_o = nsum[NIB_W];  end
            OP_SUB:   begin res_o = diff[DATA_W-1:0]; c_o = diff[DATA_W]; dc_o = ndiff[NIB_W]; end
            OP_AND:   res_o = opnd_i & w_i;
            OP_IOR:   res_o = opnd_i | w_i;
            OP_XOR:   res_o = opnd_i ^ w_i;
            OP_PASSF, OP_PASSK: res_o = opnd_i;
            OP_PASSW: res_o = w_i;
            OP_COM:   res_o = ~opnd_i;
            OP_INC:   res_o = opnd_i + DATA_W'(1);
            OP_DEC:   res_o = opnd_i - DATA_W'(1);
            OP_RL:    begin res_o = {opnd_i[DATA_W-2:0], carry_i}; c_o = opnd_i[DATA_W-1]; end
            OP_RR:    begin res_o = {carry_i, opnd_i[DATA_W-1:1]}; c_o = opnd_i[0]; end
            OP_SWAP:  res_o = {opnd_i[NIB_W-1:0], opnd_i[DATA_W-1:NIB_W]};
            OP_BCLR:  res_o = opnd_i & ~bmask;
            OP_BSET:  res_o = opnd_i | bmask;
            default:  res_o = '0;
        endcase
        z_o = (res_o == '0);
    end
endmodule

// File: rtl/acc_alu14_stmerge.sv
module acc_alu14_stmerge
    import acc_alu14_pkg::*;
#(
    parameter int unsigned STATUS_ADDR = 3,
    parameter int unsigned C_POS       = 0,
    parameter int unsigned DC_POS      = 1,
    parameter int unsigned Z_POS       = 2
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              to_file_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        we_i,
    input  logic [2:0]        fl_i,
    output logic [DATA_W-1:0] res_o
);
    logic hit;
    assign hit = to_file_i && (addr_i == ADDR_W'(STATUS_ADDR));

    always_comb begin
        res_o = raw_i;
        if (hit) begin
            if (we_i[2]) res_o[C_POS]  = fl_i[2];
            if (we_i[1]) res_o[DC_POS] = fl_i[1];
            if (we_i[0]) res_o[Z_POS]  = fl_i[0];
        end
    end
endmodule

// File: rtl/acc_alu14.sv
module acc_alu14
    import acc_alu14_pkg::*;
#(
    parameter int unsigned STATUS_ADDR = 3,
    parameter int unsigned C_POS       = 0,
    parameter int unsigned DC_POS      = 1,
    parameter int unsigned Z_POS       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [13:0]       instr_i,
    input  logic [7:0]        w_i,
    input  logic [7:0]        file_i,
    input  logic              carry_i,
    output logic [7:0]        result_o,
    output logic              wr_en_o,
    output logic              to_file_o,
    output logic [6:0]        file_addr_o,
    output logic              c_o,
    output logic              dc_o,
    output logic              z_o,
    output logic              c_we_o,
    output logic              dc_we_o,
    output logic              z_we_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] opnd, alu_res, merged;
    logic              alu_c, alu_dc, alu_z;
    logic [2:0]        we_vec, fl_vec;
    stage_t            stage_d, stage_q;

    acc_alu14_decode u_dec (
        .hi_i   (instr_i[INSN_W-1:ADDR_W]),
        .ctrl_o (ctrl)
    );

    assign opnd = ctrl.src_lit ? instr_i[DATA_W-1:0] : file_i;

    acc_alu14_alu u_alu (
        .op_i    (ctrl.op),
        .opnd_i  (opnd),
        .w_i     (w_i),
        .carry_i (carry_i),
        .bsel_i  (instr_i[ADDR_W +: BSEL_W]),
        .res_o   (alu_res),
        .c_o     (alu_c),
        .dc_o    (alu_dc),
        .z_o     (alu_z)
    );

    assign we_vec = {ctrl.upd_c, ctrl.upd_dc, ctrl.upd_z};
    assign fl_vec = {alu_c, alu_dc, alu_z} & we_vec;

    acc_alu14_stmerge #(
        .STATUS_ADDR (STATUS_ADDR),
        .C_POS       (C_POS),
        .DC_POS      (DC_POS),
        .Z_POS       (Z_POS)
    ) u_merge (
        .raw_i     (alu_res),
        .to_file_i (ctrl.wr && ctrl.to_file),
        .addr_i    (instr_i[ADDR_W-1:0]),
        .we_i      (we_vec),
        .fl_i      (fl_vec),
        .res_o     (merged)
    );

    always_comb begin
        stage_d         = '0;
        stage_d.wr      = ctrl.wr;
        stage_d.to_file = ctrl.wr && ctrl.to_file;
        stage_d.addr    = instr_i[ADDR_W-1:0];
        stage_d.res     = ctrl.wr ? merged : '0;
        stage_d.c_we    = we_vec[2];
        stage_d.dc_we   = we_vec[1];
        stage_d.z_we    = we_vec[0];
        stage_d.c       = fl_vec[2];
        stage_d.dc      = fl_vec[1];
        stage_d.z       = fl_vec[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign result_o    = stage_q.res;
    assign wr_en_o     = stage_q.wr;
    assign to_file_o   = stage_q.to_file;
    assign file_addr_o = stage_q.addr;
    assign c_o         = stage_q.c;
    assign dc_o        = stage_q.dc;
    assign z_o         = stage_q.z;
    assign c_we_o      = stage_q.c_we;
    assign dc_we_o     = stage_q.dc_we;
    assign z_we_o      = stage_q.z_we;
endmodule

// File: rtl/acc_alu14_chk.sv
module acc_alu14_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] instr_i,
    input logic        wr_en_o,
    input logic        to_file_o,
    input logic [6:0]  file_addr_o,
    input logic        z_o,
    input logic        c_we_o,
    input logic        dc_we_o,
    input logic        z_we_o
);
    // R1: first edge out of reset still shows the quiet reset state
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wr_en_o && !to_file_o && !c_we_o && !dc_we_o && !z_we_o));

    // R2: byte-oriented file destination carries the address field one edge later
    a_r2_file_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[13:12] == 2'b00 && instr_i[7]) |=>
        (!to_file_o || file_addr_o == $past(instr_i[6:0])));

    // R6: rotates touch only the carry flag
    a_r6_rot_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[13:9] == 5'b00110) |=> (c_we_o && !dc_we_o && !z_we_o && wr_en_o));

    // R7: swap changes no flag
    a_r7_swap_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[13:8] == 6'b001110) |=> (wr_en_o && !c_we_o && !dc_we_o && !z_we_o));

    // R9: clears always raise Z
    a_r9_clear_z: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[13:8] == 6'b000001) |=> (wr_en_o && z_we_o && z_o && !c_we_o));

    // R11: control-transfer words are silent
    a_r11_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[13:12] == 2'b10) |=> (!wr_en_o && !c_we_o && !dc_we_o && !z_we_o));
endmodule

bind acc_alu14 acc_alu14_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_i     (instr_i),
    .wr_en_o     (wr_en_o),
    .to_file_o   (to_file_o),
    .file_addr_o (file_addr_o),
    .z_o         (z_o),
    .c_we_o      (c_we_o),
    .dc_we_o     (dc_we_o),
    .z_we_o      (z_we_o)
);

// File: tb/acc_alu14_test.sv
module acc_alu14_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr_i = '0;
    logic [7:0]  w_i = '0;
    logic [7:0]  file_i = '0;
    logic        carry_i = 1'b0;
    logic [7:0]  result_o;
    logic        wr_en_o, to_file_o;
    logic [6:0]  file_addr_o;
    logic        c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    acc_alu14 uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .w_i(w_i), .file_i(file_i),
        .carry_i(carry_i), .result_o(result_o), .wr_en_o(wr_en_o), .to_file_o(to_file_o),
        .file_addr_o(file_addr_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o),
        .c_we_o(c_we_o), .dc_we_o(dc_we_o), .z_we_o(z_we_o)
    );

    task automatic op(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f, input logic c);
        @(negedge clk);
        instr_i = ins; w_i = w; file_i = f; carry_i = c;
        @(posedge clk);
        #1;
    endtask

    // we/fl order: {C, DC, Z}
    task automatic expect_out(input string tag, input logic e_wr, input logic e_tf,
                              input logic [6:0] e_addr, input logic [7:0] e_res,
                              input logic [2:0] e_we, input logic [2:0] e_fl);
        logic ok;
        ok = (wr_en_o === e_wr) && ({c_we_o, dc_we_o, z_we_o} === e_we)
             && ((({c_o, dc_o, z_o}) & e_we) === (e_fl & e_we));
        if (e_wr)
            ok = ok && (to_file_o === e_tf) && (result_o === e_res)
                    && (!e_tf || file_addr_o === e_addr);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual wr=%b tf=%b addr=%h res=%h we=%b fl=%b expected wr=%b tf=%b addr=%h res=%h we=%b fl=%b",
                     tag, wr_en_o, to_file_o, file_addr_o, result_o, {c_we_o, dc_we_o, z_we_o},
                     {c_o, dc_o, z_o}, e_wr, e_tf, e_addr, e_res, e_we, e_fl);
        end
    endtask

    function automatic logic [7:0] wpick(input int i);
        return (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h5A : 8'h3C;
    endfunction

    initial begin
        int s;
        logic dd;
        logic [6:0] ad;
        logic [7:0] wv, fv, rv;

        // R1: reset dominates a write instruction on the inputs
        instr_i = 14'b00_0111_1_0100000; w_i = 8'h11; file_i = 8'h22;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 1'b0, 1'b0, 7'h0, 8'h00, 3'b000, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: add, full sweep of both operands
        for (int w = 0; w < 256; w++) begin
            for (int f = 0; f < 256; f++) begin
                wv = 8'(w); fv = 8'(f);
                dd = wv[0] ^ fv[0];
                ad = 7'(32 + (f % 64));
                op({6'b000111, dd, ad}, wv, fv, fv[1]);
                s = w + f;
                expect_out("R2 R3 add", 1'b1, dd, ad, 8'(s), 3'b111,
                           {s > 255, ((w % 16) + (f % 16)) > 15, (s % 256) == 0});
            end
        end

        // R4: subtract, full sweep of both operands
        for (int w = 0; w < 256; w++) begin
            for (int f = 0; f < 256; f++) begin
                wv = 8'(w); fv = 8'(f);
                dd = wv[1] ^ fv[0];
                ad = 7'(64 + (f % 32));
                op({6'b000010, dd, ad}, wv, fv, 1'b0);
                s = f - w;
                expect_out("R4 sub", 1'b1, dd, ad, 8'(s), 3'b111,
                           {f >= w, (f % 16) >= (w % 16), (s % 256) == 0});
            end
        end

        // R3 R4 R12: literal add/sub with don't-care bit toggled
        for (int w = 0; w < 256; w++) begin
            for (int i = 0; i < 4; i++) begin
                int k;
                k = (w * 37 + i * 91) % 256;
                wv = 8'(w);
                s = w + k;
                op({5'b11111, i[0], 8'(k)}, wv, ~8'(k), 1'b1);
                expect_out("R3 addlw", 1'b1, 1'b0, 7'h0, 8'(s), 3'b111,
                           {s > 255, ((w % 16) + (k % 16)) > 15, (s % 256) == 0});
                s = k - w;
                op({5'b11110, i[1], 8'(k)}, wv, 8'(k), 1'b0);
                expect_out("R4 sublw", 1'b1, 1'b0, 7'h0, 8'(s), 3'b111,
                           {k >= w, (k % 16) >= (w % 16), (s % 256) == 0});
            end
        end

        // R5: logic operations, file and literal forms
        for (int f = 0; f < 256; f++) begin
            for (int i = 0; i < 4; i++) begin
                fv = 8'(f); wv = wpick(i); dd = fv[0]; ad = 7'h51;
                rv = fv & wv; op({6'b000101, dd, ad}, wv, fv, 1'b0);
                expect_out("R5 andwf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
                rv = fv | wv; op({6'b000100, dd, ad}, wv, fv, 1'b0);
                expect_out("R5 iorwf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
                rv = fv ^ wv; op({6'b000110, dd, ad}, wv, fv, 1'b0);
                expect_out("R5 xorwf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
                rv = fv & wv; op({6'b111001, fv}, wv, 8'h00, 1'b0);
                expect_out("R5 andlw", 1'b1, 1'b0, 7'h0, rv, 3'b001, {2'b00, rv == 0});
                rv = fv | wv; op({6'b111000, fv}, wv, 8'hFF, 1'b0);
                expect_out("R5 iorlw", 1'b1, 1'b0, 7'h0, rv, 3'b001, {2'b00, rv == 0});
                rv = fv ^ wv; op({6'b111010, fv}, wv, 8'h33, 1'b0);
                expect_out("R5 xorlw", 1'b1, 1'b0, 7'h0, rv, 3'b001, {2'b00, rv == 0});
            end
        end

        // R5 R7: one-operand operations over every byte
        for (int f = 0; f < 256; f++) begin
            fv = 8'(f); dd = fv[1]; ad = 7'h50; wv = 8'hC3;
            rv = ~fv;        op({6'b001001, dd, ad}, wv, fv, 1'b0);
            expect_out("R5 comf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
            rv = fv + 8'd1;  op({6'b001010, dd, ad}, wv, fv, 1'b0);
            expect_out("R5 incf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
            rv = fv - 8'd1;  op({6'b000011, dd, ad}, wv, fv, 1'b0);
            expect_out("R5 decf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
            rv = fv;         op({6'b001000, dd, ad}, wv, fv, 1'b0);
            expect_out("R5 movf", 1'b1, dd, ad, rv, 3'b001, {2'b00, rv == 0});
            rv = {fv[3:0], fv[7:4]}; op({6'b001110, dd, ad}, wv, fv, 1'b1);
            expect_out("R7 swapf", 1'b1, dd, ad, rv, 3'b000, 3'b000);
            rv = fv + 8'd1;  op({6'b001111, dd, ad}, wv, fv, 1'b0);
            expect_out("R7 incfsz", 1'b1, dd, ad, rv, 3'b000, 3'b000);
            rv = fv - 8'd1;  op({6'b001011, dd, ad}, wv, fv, 1'b0);
            expect_out("R7 decfsz", 1'b1, dd, ad, rv, 3'b000, 3'b000);
        end

        // R6: rotates through carry
        for (int f = 0; f < 256; f++) begin
            for (int c = 0; c < 2; c++) begin
                fv = 8'(f); dd = fv[2]; ad = 7'h12;
                op({6'b001101, dd, ad}, 8'h00, fv, c[0]);
                expect_out("R6 rlf", 1'b1, dd, ad, {fv[6:0], c[0]}, 3'b100, {fv[7], 2'b00});
                op({6'b001100, dd, ad}, 8'h00, fv, c[0]);
                expect_out("R6 rrf", 1'b1, dd, ad, {c[0], fv[7:1]}, 3'b100, {fv[0], 2'b00});
            end
        end

        // R7 R12: moves of W and literal
        for (int k = 0; k < 256; k++) begin
            fv = 8'(k);
            op({7'b0000001, 7'h2A}, fv, ~fv, 1'b0);
            expect_out("R7 movwf", 1'b1, 1'b1, 7'h2A, fv, 3'b000, 3'b000);
            op({4'b1100, 2'(k % 4), fv}, ~fv, 8'h00, 1'b0);
            expect_out("R12 movlw", 1'b1, 1'b0, 7'h0, fv, 3'b000, 3'b000);
            op({4'b1101, 2'(k / 64), fv}, 8'h77, 8'h00, 1'b1);
            expect_out("R7 retlw", 1'b1, 1'b0, 7'h0, fv, 3'b000, 3'b000);
        end

        // R8: bit clear and set on every bit
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 4; i++) begin
                fv = wpick(i) ^ 8'(b * 17);
                op({4'b0100, 3'(b), 7'h45}, 8'hAA, fv, 1'b1);
                expect_out("R8 bcf", 1'b1, 1'b1, 7'h45, fv & ~(8'd1 << b), 3'b000, 3'b000);
                op({4'b0101, 3'(b), 7'h45}, 8'h55, fv, 1'b0);
                expect_out("R8 bsf", 1'b1, 1'b1, 7'h45, fv | (8'd1 << b), 3'b000, 3'b000);
            end
        end

        // R9: clears
        for (int i = 0; i < 128; i++) begin
            op({7'b0000010, 7'(i)}, 8'h9C, 8'hE1, 1'b1);
            expect_out("R9 clrw", 1'b1, 1'b0, 7'h0, 8'h00, 3'b001, 3'b001);
            if (i != 3) begin
                op({7'b0000011, 7'(i)}, 8'h9C, 8'hE1, 1'b1);
                expect_out("R9 clrf", 1'b1, 1'b1, 7'(i), 8'h00, 3'b001, 3'b001);
            end
        end

        // R10: status register as destination
        op({7'b0000011, 7'd3}, 8'h5A, 8'hFF, 1'b1);
        expect_out("R10 clrf status", 1'b1, 1'b1, 7'd3, 8'h04, 3'b001, 3'b001);
        op({6'b000111, 1'b1, 7'd3}, 8'h01, 8'hFF, 1'b0);
        expect_out("R10 addwf status", 1'b1, 1'b1, 7'd3, 8'h07, 3'b111, 3'b111);
        op({6'b000111, 1'b1, 7'd3}, 8'h01, 8'h20, 1'b0);
        expect_out("R10 addwf status nc", 1'b1, 1'b1, 7'd3, 8'h20, 3'b111, 3'b000);
        op({6'b001101, 1'b1, 7'd3}, 8'h00, 8'h80, 1'b0);
        expect_out("R10 rlf status", 1'b1, 1'b1, 7'd3, 8'h01, 3'b100, 3'b100);
        op({7'b0000001, 7'd3}, 8'hFF, 8'h00, 1'b0);
        expect_out("R10 movwf status", 1'b1, 1'b1, 7'd3, 8'hFF, 3'b000, 3'b000);
        op({6'b001110, 1'b1, 7'd3}, 8'h00, 8'h5A, 1'b0);
        expect_out("R10 swapf status", 1'b1, 1'b1, 7'd3, 8'hA5, 3'b000, 3'b000);
        op({6'b000111, 1'b0, 7'd3}, 8'h01, 8'hFF, 1'b0);
        expect_out("R10 addwf to W", 1'b1, 1'b0, 7'd3, 8'h00, 3'b111, 3'b111);

        // R11: reserved and control words
        for (int i = 0; i < 256; i++) begin
            if (i < 128) begin
                op({7'b0000000, 7'(i)}, 8'h12, 8'h34, 1'b1);
                expect_out("R11 zero group", 1'b0, 1'b0, 7'h0, 8'h00, 3'b000, 3'b000);
            end
            op({3'b011, 11'(i * 8 + 3)}, 8'h12, 8'h34, 1'b0);
            expect_out("R11 bit tests", 1'b0, 1'b0, 7'h0, 8'h00, 3'b000, 3'b000);
            op({2'b10, 12'(i * 16 + 5)}, 8'h12, 8'h34, 1'b0);
            expect_out("R11 branches", 1'b0, 1'b0, 7'h0, 8'h00, 3'b000, 3'b000);
            op({6'b111011, 8'(i)}, 8'h00, 8'h00, 1'b1);
            expect_out("R11 reserved literal", 1'b0, 1'b0, 7'h0, 8'h00, 3'b000, 3'b000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule